// File: doc/BRIEF.md
# Two-Line Stereo Serializer for a 16-bit Multibit DAC

This block sits between a standard I2S stereo source and a 16-bit multibit converter that accepts its two channel words on separate data lines. It receives the I2S bit clock, word select and serial data, and brings them into a fast system clock domain. It keeps the top 16 bits of each left and right slot. It then shifts both words out together on two lines, one per channel, under a single output bit clock.

Once a stereo pair is complete, the output side produces 16 bit-clock pulses and then lowers a latch-enable strobe. The converter loads both words on the first rising output bit-clock edge after the strobe has gone low. That edge is the first pulse of the next output frame, after which the strobe returns high. Two lines in parallel need only half the bit-clock pulses that an I2S frame carries. A converter limited to a 6.4 MHz bit clock can therefore accept sample rates up to 400 kHz, including 384 kHz, and a 352.8 kHz stream needs only 5.6448 MHz.

The output bit-clock half period is a parameter counted in system clock cycles. The default of 20 cycles at 250 MHz gives 6.25 MHz.

Top module: `sms_serializer`

## Requirements
- R1: While reset is asserted, and after it is released until a new stereo pair is complete, `dac_le` is 1 and `dac_bck`, `dac_dl` and `dac_dr` are 0. A frame that was only partly received or partly sent when reset arrived is never delivered.
- R2: A new word starts with the bit on the first input bit-clock rising edge after a word-select change, and it belongs to the word-select level sampled one edge earlier. Level 0 means left, which is sent on `dac_dl`, and level 1 means right, which is sent on `dac_dr`.
- R3: Only the first 16 bits of a slot are kept. With 24-bit or 32-bit slots the remaining low-order bits have no effect on either output word.
- R4: Each word leaves in offset binary: the two's-complement input MSB is inverted, so an input of 0x0000 is delivered as 0x8000.
- R5: Both words are sent MSB first on their two lines at the same time, one bit per output bit-clock pulse.
- R6: Each output frame has exactly 16 rising edges of `dac_bck` between successive falling edges of `dac_le`.
- R7: `dac_dl`, `dac_dr` and `dac_le` change only while `dac_bck` is low, so they are stable across every high phase.
- R8: `dac_le` falls after the 16th pulse of a frame. The next frame's first rising edge therefore sees it low and latches the previous pair. `dac_le` rises again after that first pulse, so exactly one pulse occurs while it is low.
- R9: `dac_bck` is high for HALF_DIV and low for HALF_DIV system clock cycles within a frame. The default of 20 cycles gives a 160 ns period at 250 MHz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the input bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i2s_bck | input | 1 | I2S bit clock, asynchronous to clk |
| i2s_ws | input | 1 | I2S word select, 0 = left |
| i2s_sd | input | 1 | I2S serial data, two's complement, MSB first |
| dac_bck | output | 1 | Output bit clock shared by both data lines |
| dac_dl | output | 1 | Left-channel serial data, offset binary |
| dac_dr | output | 1 | Right-channel serial data, offset binary |
| dac_le | output | 1 | Latch-enable strobe, low after the last bit of a frame |

## Verification
An output frame starts a few system cycles after the 16th right-channel input bit: the synchronizer stages, one edge-detect register and one load cycle. Its first rising `dac_bck` edge comes HALF_DIV cycles later, and `dac_le` falls 32*HALF_DIV cycles after the load. Each pair is delivered only at the first rising edge of the following frame. The bench therefore queues the expected pair when it sends a frame and pops it in a converter model at that later edge, rather than at a fixed delay. The model samples 1 ns after each rising `dac_bck` edge and again 1 ns before the following falling edge, clear of any system clock edge, and times the intervals between pulses. One final stream flushes the last pair.

// File: rtl/sms_pkg.sv
`timescale 1ns/1ps
package sms_pkg;
  typedef enum logic {TX_IDLE = 1'b0, TX_RUN = 1'b1} tx_state_e;
endpackage

// File: rtl/sms_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer for a bundle of asynchronous lines.
module sms_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= '0;
          else        stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign d_sync = stage_q[STAGES-1];
endmodule

// File: rtl/sms_i2s_rx.sv
`timescale 1ns/1ps
// I2S receiver: one-bit delayed framing, keeps the top WORD_W bits of a slot.
module sms_i2s_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck_s,
  input  logic              ws_s,
  input  logic              sd_s,
  output logic              pair_stb,
  output logic [WORD_W-1:0] left_word,
  output logic [WORD_W-1:0] right_word
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic              bck_q, bck_n;
  logic              ws_h1_q, ws_h1_n, ws_h2_q, ws_h2_n;
  logic [1:0]        hist_q, hist_n;
  logic              act_q, act_n;
  logic              ch_q, ch_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [WORD_W-1:0] left_q, left_n, right_q, right_n;
  logic              lok_q, lok_n;
  logic              stb_q, stb_n;

  logic rise, start, done;

  always_comb begin
    bck_n   = bck_s;
    ws_h1_n = ws_h1_q;
    ws_h2_n = ws_h2_q;
    hist_n  = hist_q;
    act_n   = act_q;
    ch_n    = ch_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    left_n  = left_q;
    right_n = right_q;
    lok_n   = lok_q;
    stb_n   = 1'b0;
    rise    = bck_s & ~bck_q;
    start   = 1'b0;
    done    = 1'b0;
    if (rise) begin
      ws_h1_n = ws_s;
      ws_h2_n = ws_h1_q;
      if (hist_q != 2'd2) hist_n = hist_q + 2'd1;
      start = (hist_q == 2'd2) && (ws_h1_q != ws_h2_q);
      if (start) begin
        act_n = 1'b1;
        ch_n  = ws_h1_q;
        cnt_n = CNT_W'(1);
        sh_n  = {sh_q[WORD_W-2:0], sd_s};
        if (!ws_h1_q) lok_n = 1'b0;
      end else if (act_q && (cnt_q != CNT_FULL)) begin
        cnt_n = cnt_q + CNT_W'(1);
        sh_n  = {sh_q[WORD_W-2:0], sd_s};
        done  = (cnt_q == CNT_LAST);
      end
      if (done) begin
        if (!ch_q) begin
          left_n = sh_n;
          lok_n  = 1'b1;
        end else if (lok_q) begin
          right_n = sh_n;
          stb_n   = 1'b1;
          lok_n   = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q   <= 1'b0;
      ws_h1_q <= 1'b0;
      ws_h2_q <= 1'b0;
      hist_q  <= 2'd0;
      act_q   <= 1'b0;
      ch_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      right_q <= '0;
      lok_q   <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      bck_q   <= bck_n;
      ws_h1_q <= ws_h1_n;
      ws_h2_q <= ws_h2_n;
      hist_q  <= hist_n;
      act_q   <= act_n;
      ch_q    <= ch_n;
      cnt_q   <= cnt_n;
      sh_q    <= sh_n;
      left_q  <= left_n;
      right_q <= right_n;
      lok_q   <= lok_n;
      stb_q   <= stb_n;
    end
  end

  assign pair_stb   = stb_q;
  assign left_word  = left_q;
  assign right_word = right_q;
endmodule

// File: rtl/sms_tx.sv
`timescale 1ns/1ps
// Two-line transmitter: bit clock divider, parallel shifters, latch strobe.
module sms_tx
  import sms_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int HALF_DIV = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pair_stb,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              dac_bck,
  output logic              dac_dl,
  output logic              dac_dr,
  output logic              dac_le
);
  localparam int DIV_W = $clog2(HALF_DIV);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0]  DIV_END  = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST = BIT_W'(WORD_W - 1);
  localparam logic [WORD_W-1:0] MSB_FLIP = {1'b1, {(WORD_W-1){1'b0}}};

  tx_state_e         st_q, st_n;
  logic              pend_q, pend_n;
  logic [WORD_W-1:0] pl_q, pl_n, pr_q, pr_n;
  logic [WORD_W-1:0] shl_q, shl_n, shr_q, shr_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic [BIT_W-1:0]  bit_q, bit_n;
  logic              bck_q, bck_n, le_q, le_n, dl_q, dl_n, dr_q, dr_n;
  logic              tick;

  always_comb begin
    st_n   = st_q;
    pend_n = pend_q;
    pl_n   = pl_q;
    pr_n   = pr_q;
    shl_n  = shl_q;
    shr_n  = shr_q;
    div_n  = div_q;
    bit_n  = bit_q;
    bck_n  = bck_q;
    le_n   = le_q;
    dl_n   = dl_q;
    dr_n   = dr_q;
    tick   = (st_q == TX_RUN) && (div_q == DIV_END);
    if (pair_stb) begin
      pend_n = 1'b1;
      pl_n   = left_in;
      pr_n   = right_in;
    end
    case (st_q)
      TX_IDLE: begin
        if (pend_q) begin
          st_n  = TX_RUN;
          div_n = '0;
          bit_n = '0;
          shl_n = pl_q ^ MSB_FLIP;
          shr_n = pr_q ^ MSB_FLIP;
          dl_n  = ~pl_q[WORD_W-1];
          dr_n  = ~pr_q[WORD_W-1];
          if (!pair_stb) pend_n = 1'b0;
        end
      end
      default: begin
        if (tick) begin
          div_n = '0;
          if (!bck_q) begin
            bck_n = 1'b1;
          end else begin
            bck_n = 1'b0;
            if (bit_q == BIT_LAST) begin
              st_n = TX_IDLE;
              le_n = 1'b0;
            end else begin
              bit_n = bit_q + BIT_W'(1);
              shl_n = {shl_q[WORD_W-2:0], 1'b0};
              shr_n = {shr_q[WORD_W-2:0], 1'b0};
              dl_n  = shl_q[WORD_W-2];
              dr_n  = shr_q[WORD_W-2];
              if (!le_q) le_n = 1'b1;
            end
          end
        end else begin
          div_n = div_q + DIV_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      pend_q <= 1'b0;
      pl_q   <= '0;
      pr_q   <= '0;
      shl_q  <= '0;
      shr_q  <= '0;
      div_q  <= '0;
      bit_q  <= '0;
      bck_q  <= 1'b0;
      le_q   <= 1'b1;
      dl_q   <= 1'b0;
      dr_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      pend_q <= pend_n;
      pl_q   <= pl_n;
      pr_q   <= pr_n;
      shl_q  <= shl_n;
      shr_q  <= shr_n;
      div_q  <= div_n;
      bit_q  <= bit_n;
      bck_q  <= bck_n;
      le_q   <= le_n;
      dl_q   <= dl_n;
      dr_q   <= dr_n;
    end
  end

  assign dac_bck = bck_q;
  assign dac_dl  = dl_q;
  assign dac_dr  = dr_q;
  assign dac_le  = le_q;
endmodule

// File: rtl/sms_serializer.sv
`timescale 1ns/1ps
module sms_serializer #(
  parameter int WORD_W      = 16,
  parameter int HALF_DIV    = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i2s_bck,
  input  logic i2s_ws,
  input  logic i2s_sd,
  output logic dac_bck,
  output logic dac_dl,
  output logic dac_dr,
  output logic dac_le
);
  logic [2:0]        line_s;
  logic              stb;
  logic [WORD_W-1:0] lw, rw;

  sms_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({i2s_bck, i2s_ws, i2s_sd}),
    .d_sync  (line_s)
  );

  sms_i2s_rx #(.WORD_W(WORD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .bck_s      (line_s[2]),
    .ws_s       (line_s[1]),
    .sd_s       (line_s[0]),
    .pair_stb   (stb),
    .left_word  (lw),
    .right_word (rw)
  );

  sms_tx #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .pair_stb (stb),
    .left_in  (lw),
    .right_in (rw),
    .dac_bck  (dac_bck),
    .dac_dl   (dac_dl),
    .dac_dr   (dac_dr),
    .dac_le   (dac_le)
  );
endmodule

// File: rtl/sms_serializer_chk.sv
`timescale 1ns/1ps
module sms_serializer_chk #(
  parameter int WORD_W = 16
) (
  input logic clk,
  input logic rst_n,
  input logic dac_bck,
  input logic dac_dl,
  input logic dac_dr,
  input logic dac_le
);
  localparam int PC_W = $clog2(WORD_W + 2);

  logic            bck_d, le_d;
  logic [PC_W-1:0] pulses;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_d  <= 1'b0;
      le_d   <= 1'b1;
      pulses <= '0;
    end else begin
      bck_d <= dac_bck;
      le_d  <= dac_le;
      if (le_d && !dac_le)       pulses <= '0;
      else if (dac_bck && !bck_d) pulses <= pulses + PC_W'(1);
    end
  end

  p_frame_pulses_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (le_d && !dac_le) |-> (pulses == PC_W'(WORD_W)));

  p_pulse_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= PC_W'(WORD_W));

  p_data_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_dl) || !$stable(dac_dr)) |-> !dac_bck);

  p_strobe_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_le) |-> !dac_bck);

  p_high_phase_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dac_bck) |=> dac_bck);
endmodule

bind sms_serializer sms_serializer_chk #(.WORD_W(WORD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dac_bck (dac_bck),
  .dac_dl  (dac_dl),
  .dac_dr  (dac_dr),
  .dac_le  (dac_le)
);

// File: tb/sms_serializer_test.sv
`timescale 1ns/1ps
module sms_serializer_test;
  localparam int W    = 16;
  localparam int HALF = 20;
  localparam int BPER = 2 * HALF * 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, i_bck, i_ws, i_sd;
  logic o_bck, o_dl, o_dr, o_le;

  sms_serializer #(.WORD_W(W), .HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .i2s_bck(i_bck), .i2s_ws(i_ws), .i2s_sd(i_sd),
    .dac_bck(o_bck), .dac_dl(o_dl), .dac_dr(o_dr), .dac_le(o_le)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  logic [W-1:0] exp_l [0:63];
  logic [W-1:0] exp_r [0:63];
  int           exp_s [0:63];
  int wr = 0, rd = 0, pulses = 0;
  longint last_rise = 0;
  logic [W-1:0] dsl = '0, dsr = '0;

  // Converter model: latch on rising edge while strobe low, then shift.
  always @(posedge o_bck) begin
    logic hd, hr, hl;
    #1;
    if ($time - last_rise < 400) chk(($time - last_rise) == BPER, "R9", $time - last_rise, BPER);
    last_rise = $time;
    if (!o_le) begin
      chk(rd < wr, "R8", rd, wr);
      if (rd < wr) begin
        chk(dsl == exp_l[rd], "R2", dsl, exp_l[rd]);
        chk(dsr == exp_r[rd], (exp_s[rd] > 16) ? "R3" : "R5", dsr, exp_r[rd]);
        if (exp_l[rd] == 16'h8000) chk(dsl == 16'h8000, "R4", dsl, 16'h8000);
        rd++;
      end
    end
    dsl = {dsl[W-2:0], o_dl};
    dsr = {dsr[W-2:0], o_dr};
    pulses++;
    hd = o_dl; hr = o_dr; hl = o_le;
    #(BPER/2 - 2);
    if (rst_n) chk({o_dl, o_dr, o_le} == {hd, hr, hl}, "R7", {o_dl, o_dr, o_le}, {hd, hr, hl});
  end

  always @(negedge o_le) begin
    chk(pulses == W, "R6", pulses, W);
    pulses = 0;
  end

  always @(posedge o_le) if (rst_n) chk(pulses == 1, "R8", pulses, 1);

  function automatic logic [15:0] top_pat(input int f, input bit right);
    logic [15:0] l;
    case (f)
      0: l = 16'h0000;
      1: l = 16'h8000;
      2: l = 16'hA5A5;
      3: l = 16'h7FFF;
      default: l = 16'h0001 << ((f - 4) % 16);
    endcase
    return right ? (~l ^ 16'(f * 16'h1357)) : l;
  endfunction

  task automatic drive_bit(input logic ws, input logic sd);
    i_ws = ws;
    i_sd = sd;
    #80 i_bck = 1'b1;
    #80 i_bck = 1'b0;
  endtask

  task automatic send_stream(input int first, input int nfr, input int slot);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b0, 1'b0);
    for (int f = first; f < first + nfr; f++) begin
      logic [15:0] tl, tr;
      logic [31:0] lv, rv, junk;
      tl   = top_pat(f, 1'b0);
      tr   = top_pat(f, 1'b1);
      junk = 32'(f) * 32'h9E3779B1;
      lv   = (32'(tl) << (slot - 16)) | (junk & ((32'd1 << (slot - 16)) - 32'd1));
      rv   = (32'(tr) << (slot - 16)) | ((~junk) & ((32'd1 << (slot - 16)) - 32'd1));
      exp_l[wr] = tl ^ 16'h8000;
      exp_r[wr] = tr ^ 16'h8000;
      exp_s[wr] = slot;
      wr++;
      for (int p = 0; p < 2 * slot; p++) begin
        logic b, w;
        b = (p < slot) ? lv[slot-1-p] : rv[2*slot-1-p];
        w = ((p + 1) >= slot) && ((p + 1) < 2 * slot);
        drive_bit(w, b);
      end
    end
  endtask

  task automatic idle_check(input string req, input int ns);
    int p0;
    p0 = pulses;
    #(ns);
    chk(pulses == p0, req, pulses - p0, 0);
    chk({o_bck, o_dl, o_dr, o_le} == 4'b0001, req, {o_bck, o_dl, o_dr, o_le}, 4'b0001);
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp + 1, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; i_bck = 1'b0; i_ws = 1'b0; i_sd = 1'b0;
    #21;
    chk({o_bck, o_dl, o_dr, o_le} == 4'b0001, "R1", {o_bck, o_dl, o_dr, o_le}, 4'b0001);
    #20 rst_n = 1'b1;
    idle_check("R1", 1000);

    send_stream(0, 20, 16);

    // Partial frame cut by reset (R1): the last queued pair is dropped too.
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b1, 1'b0);
    drive_bit(1'b0, 1'b0);
    for (int p = 0; p < 32 + 20; p++) drive_bit((p >= 31) ? 1'b1 : 1'b0, p[0] ^ p[2]);
    #3;
    rst_n = 1'b0;
    #7;
    chk({o_bck, o_dl, o_dr, o_le} == 4'b0001, "R1", {o_bck, o_dl, o_dr, o_le}, 4'b0001);
    rd = wr;
    pulses = 0;
    #40 rst_n = 1'b1;
    idle_check("R1", 3000);

    send_stream(20, 8, 24);
    send_stream(28, 8, 32);
    send_stream(36, 1, 16);
    #4000;
    chk(rd == wr - 1, "R8", rd, wr - 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule